// File: doc/BRIEF.md
# System Tick Compare Timer

This block keeps a free-running 63-bit system tick counter and two 64-bit compare registers, one owned by the supervisor and one by the hypervisor. When an armed compare register's low 63 bits equal the counter and its top bit, the disable bit, is clear, the comparator raises a one-cycle event. A supervisor event sets the timer bit of a 17-bit soft interrupt register. A hypervisor event sets a hypervisor pending flag, which drives a dedicated interrupt line.

Software reaches the counter, both compare registers, the soft interrupt register and the pending flag through a single-cycle register port. Read data is registered and valid one cycle after the address is presented. The state of the owning strand comes in on a 2-bit input. It decides whether a late match is delivered, and whether a hypervisor match is dropped.

Top module: `stc_timer`

## Requirements
- R1: The counter (address 0) advances by one on every clock, wraps from 2^63-1 to 0, loads the low 63 bits of the write data when address 0 is written, and reads back on address 0 with bit 63 as zero.
- R2: After reset both compare registers (supervisor at address 1, hypervisor at address 2) read 0x8000000000000000, the soft interrupt register and the pending flag read zero, and both interrupt outputs are low.
- R3: A comparator is armed by a write to its compare register with bit 63 clear. Its event fires once when the counter equals bits 62:0 of that register, and firing disarms it.
- R4: A compare register holding bit 63 = 1 produces no event, and writing bit 63 = 1 cancels a pending match of that comparator.
- R5: A supervisor event sets bit 16 of the soft interrupt register. `soft_timer_irq` mirrors that bit and rises on the clock after the counter reaches the compare value.
- R6: A hypervisor event sets the pending flag (address 6, bit 0), and `hyp_irq` is high while the flag is 1.
- R7: Writing 0 to bit 0 at address 6 clears the pending flag, and `hyp_irq` falls on the next clock.
- R8: While `strand_state` is 2 (halted) or 3 (unallocated), a hypervisor match is consumed without setting the pending flag.
- R9: While `strand_state` is 1 (suspended), an armed comparator whose target is already below the counter fires on the next cycle.
- R10: While `strand_state` is 0 (running), a target already below the counter produces no event until the counter wraps round to it.
- R11: The soft interrupt register is written at address 3, set with write-one bits at address 4 and cleared with write-one bits at address 5. Each of these addresses reads back its 17 bits. A timer event in the same cycle as a write wins for bit 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Registered read data for the address of the previous cycle |
| strand_state | input | 2 | 0 running, 1 suspended, 2 halted, 3 unallocated |
| soft_int | output | 17 | Soft interrupt register contents |
| soft_timer_irq | output | 1 | Timer bit of the soft interrupt register |
| hyp_irq | output | 1 | Hypervisor pending interrupt line |

## Verification
The embedded assertions check these rules on every cycle: the counter steps by one unless it is loaded, a comparator never fires twice without a new write, and a disabling write suppresses the next cycle's event. They also check that each event sets its sink on the following clock, that a clear of the pending flag takes effect, and that no hypervisor event leaves the comparator while the strand is halted or unallocated. Some behaviour can only be shown by the bench's scenarios, which compare the exact cycle at which each interrupt rises with a predicted cycle: the reset values, equality-only matching with a target below the counter, catching up after wrap, late delivery while suspended, and the three soft interrupt write modes.

// File: rtl/stc_pkg.sv
package stc_pkg;

  typedef enum logic [2:0] {
    SEL_COUNT = 3'd0,
    SEL_SCMP  = 3'd1,
    SEL_HCMP  = 3'd2,
    SEL_SOFT  = 3'd3,
    SEL_SSET  = 3'd4,
    SEL_SCLR  = 3'd5,
    SEL_HPEND = 3'd6,
    SEL_NONE  = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    STRAND_RUN     = 2'd0,
    STRAND_SUSP    = 2'd1,
    STRAND_HALT    = 2'd2,
    STRAND_UNALLOC = 2'd3
  } strand_e;

endpackage

// File: rtl/stc_counter.sv
module stc_counter #(
  parameter int CNT_W = 63
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst)     cnt <= '0;
    else if (ld) cnt <= ld_val;
    else         cnt <= cnt + 1'b1;
  end

  // R1: the counter steps by one whenever it was neither reset nor loaded
  a_r1_count_step: assert property (@(posedge clk)
    $past(!rst && !ld) |-> cnt == CNT_W'($past(cnt) + 1'b1));

endmodule

// File: rtl/stc_comparator.sv
module stc_comparator
  import stc_pkg::*;
#(
  parameter int CNT_W     = 63,
  parameter bit GATE_HALT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W:0]   wdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic [1:0]       strand,
  output logic [CNT_W:0]   cmp_q,
  output logic             fire
);

  localparam int MSB = CNT_W;

  logic armed;
  logic hit_eq;
  logic hit_late;
  logic blocked;
  logic match;
  logic cancel;

  assign hit_eq   = cnt == cmp_q[CNT_W-1:0];
  assign hit_late = (strand_e'(strand) == STRAND_SUSP) && (cnt > cmp_q[CNT_W-1:0]);
  assign match    = armed && !cmp_q[MSB] && (hit_eq || hit_late);
  assign cancel   = wr && wdata[MSB];

  generate
    if (GATE_HALT) begin : g_gate
      assign blocked = (strand_e'(strand) == STRAND_HALT) ||
                       (strand_e'(strand) == STRAND_UNALLOC);
    end else begin : g_open
      assign blocked = 1'b0;
    end
  endgenerate

  assign fire = match && !blocked && !cancel;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= {1'b1, {CNT_W{1'b0}}};
      armed <= 1'b0;
    end else if (wr) begin
      cmp_q <= wdata;
      armed <= !wdata[MSB];
    end else if (match) begin
      armed <= 1'b0;
    end
  end

  // R4: a disabling write leaves no event in the following cycle
  a_r4_cancel: assert property (@(posedge clk) disable iff (rst)
    cancel |=> !fire);

  // R3: one event per arming write
  a_r3_one_shot: assert property (@(posedge clk) disable iff (rst)
    (fire && !wr) |=> !fire);

endmodule

// File: rtl/stc_irq_regs.sv
module stc_irq_regs #(
  parameter int SOFT_W    = 17,
  parameter int TIMER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_wr,
  input  logic              soft_set,
  input  logic              soft_clr,
  input  logic              hpend_wr,
  input  logic [SOFT_W-1:0] wdata,
  input  logic              sup_fire,
  input  logic              hyp_fire,
  output logic [SOFT_W-1:0] softint,
  output logic              hpend
);

  logic [SOFT_W-1:0] soft_nx;
  logic              hpend_nx;

  always_comb begin
    soft_nx = softint;
    if (soft_wr)  soft_nx = wdata;
    if (soft_set) soft_nx = soft_nx | wdata;
    if (soft_clr) soft_nx = soft_nx & ~wdata;
    if (sup_fire) soft_nx[TIMER_BIT] = 1'b1;
    hpend_nx = hpend;
    if (hpend_wr) hpend_nx = wdata[0];
    if (hyp_fire) hpend_nx = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      softint <= '0;
      hpend   <= 1'b0;
    end else begin
      softint <= soft_nx;
      hpend   <= hpend_nx;
    end
  end

  // R5: supervisor event lands in the timer bit
  a_r5_sup_sets: assert property (@(posedge clk) disable iff (rst)
    sup_fire |=> softint[TIMER_BIT]);

  // R6: hypervisor event sets the pending flag
  a_r6_hyp_sets: assert property (@(posedge clk) disable iff (rst)
    hyp_fire |=> hpend);

  // R7: zero write clears the pending flag
  a_r7_hyp_clear: assert property (@(posedge clk) disable iff (rst)
    (hpend_wr && !wdata[0] && !hyp_fire) |=> !hpend);

endmodule

// File: rtl/stc_timer.sv
module stc_timer
  import stc_pkg::*;
#(
  parameter int CNT_W     = 63,
  parameter int SOFT_W    = 17,
  parameter int TIMER_BIT = 16,
  parameter int ADDR_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W:0]    reg_wdata,
  output logic [CNT_W:0]    reg_rdata,
  input  logic [1:0]        strand_state,
  output logic [SOFT_W-1:0] soft_int,
  output logic              soft_timer_irq,
  output logic              hyp_irq
);

  localparam int REG_W = CNT_W + 1;

  reg_sel_e          sel;
  logic [CNT_W-1:0]  cnt;
  logic [REG_W-1:0]  scmp_q;
  logic [REG_W-1:0]  hcmp_q;
  logic              sup_fire;
  logic              hyp_fire;
  logic [SOFT_W-1:0] softint;
  logic              hpend;
  logic              wr_cnt, wr_scmp, wr_hcmp, wr_soft, wr_sset, wr_sclr, wr_hpend;

  assign sel      = reg_sel_e'(reg_addr);
  assign wr_cnt   = reg_wr && (sel == SEL_COUNT);
  assign wr_scmp  = reg_wr && (sel == SEL_SCMP);
  assign wr_hcmp  = reg_wr && (sel == SEL_HCMP);
  assign wr_soft  = reg_wr && (sel == SEL_SOFT);
  assign wr_sset  = reg_wr && (sel == SEL_SSET);
  assign wr_sclr  = reg_wr && (sel == SEL_SCLR);
  assign wr_hpend = reg_wr && (sel == SEL_HPEND);

  stc_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .ld(wr_cnt), .ld_val(reg_wdata[CNT_W-1:0]), .cnt(cnt)
  );

  stc_comparator #(.CNT_W(CNT_W), .GATE_HALT(1'b0)) u_sup_cmp (
    .clk(clk), .rst(rst), .wr(wr_scmp), .wdata(reg_wdata), .cnt(cnt),
    .strand(strand_state), .cmp_q(scmp_q), .fire(sup_fire)
  );

  stc_comparator #(.CNT_W(CNT_W), .GATE_HALT(1'b1)) u_hyp_cmp (
    .clk(clk), .rst(rst), .wr(wr_hcmp), .wdata(reg_wdata), .cnt(cnt),
    .strand(strand_state), .cmp_q(hcmp_q), .fire(hyp_fire)
  );

  stc_irq_regs #(.SOFT_W(SOFT_W), .TIMER_BIT(TIMER_BIT)) u_irq (
    .clk(clk), .rst(rst), .soft_wr(wr_soft), .soft_set(wr_sset), .soft_clr(wr_sclr),
    .hpend_wr(wr_hpend), .wdata(reg_wdata[SOFT_W-1:0]),
    .sup_fire(sup_fire), .hyp_fire(hyp_fire), .softint(softint), .hpend(hpend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (sel)
        SEL_COUNT:                   reg_rdata <= {1'b0, cnt};
        SEL_SCMP:                    reg_rdata <= scmp_q;
        SEL_HCMP:                    reg_rdata <= hcmp_q;
        SEL_SOFT, SEL_SSET, SEL_SCLR: reg_rdata <= REG_W'(softint);
        SEL_HPEND:                   reg_rdata <= REG_W'(hpend);
        default:                     reg_rdata <= '0;
      endcase
    end
  end

  assign soft_int       = softint;
  assign soft_timer_irq = softint[TIMER_BIT];
  assign hyp_irq        = hpend;

  // R8: no hypervisor event escapes while the strand is halted or unallocated
  a_r8_halt_drop: assert property (@(posedge clk) disable iff (rst)
    hyp_fire |-> !(strand_state == 2'd2 || strand_state == 2'd3));

endmodule

// File: tb/stc_timer_tb.sv
module stc_timer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd7;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [1:0]  strand_state = 2'd0;
  logic [16:0] soft_int;
  logic        soft_timer_irq;
  logic        hyp_irq;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  typedef struct { int kind; int at; string tag; } exp_t;
  exp_t q[$];

  localparam logic [63:0] DIS = 64'h8000_0000_0000_0000;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  stc_timer u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .strand_state(strand_state),
    .soft_int(soft_int), .soft_timer_irq(soft_timer_irq), .hyp_irq(hyp_irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // tasks are entered at a falling edge and return at a falling edge
  task automatic wr_reg(input logic [2:0] a, input logic [63:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 3'd7;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [63:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_addr = 3'd7;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_rise(input int kind, input int at, input string tag);
    exp_t e;
    e.kind = kind; e.at = at; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: every interrupt rise must match the oldest expected item
  bit p_s = 1'b0, p_h = 1'b0;
  task automatic got(input int kind);
    exp_t e;
    n_chk++;
    if (q.size() == 0) begin
      n_fail++;
      $display("FAIL unexpected rise kind=%0d at cycle %0d expected=none", kind, cyc);
    end else begin
      e = q.pop_front();
      if (e.kind != kind || e.at != cyc) begin
        n_fail++;
        $display("FAIL %s kind=%0d cycle=%0d expected kind=%0d cycle=%0d",
                 e.tag, kind, cyc, e.kind, e.at);
      end
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (soft_timer_irq && !p_s) got(0);
      if (hyp_irq && !p_h) got(1);
    end
    p_s = soft_timer_irq;
    p_h = hyp_irq;
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      for (int i = 0; i < q.size(); i++) begin
        n_chk++; n_fail++;
        $display("FAIL %s missing rise expected at cycle %0d", q[i].tag, q[i].at);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [63:0] d;
    idle(3);
    rst = 1'b0;
    @(negedge clk);

    // R2 reset state
    rd_reg(3'd1, d); check("R2 supervisor compare reset", d, DIS);
    rd_reg(3'd2, d); check("R2 hypervisor compare reset", d, DIS);
    rd_reg(3'd3, d); check("R2 soft interrupt reset", d, 64'd0);
    rd_reg(3'd6, d); check("R2 pending flag reset", d, 64'd0);
    check("R2 irq lines low", {62'd0, soft_timer_irq, hyp_irq}, 64'd0);

    // R1 counter load and readback
    wr_reg(3'd0, 64'd1000);
    rd_reg(3'd0, d); check("R1 counter readback", d, 64'd1000);
    rd_reg(3'd0, d); check("R1 counter step", d, 64'd1001);

    // R3/R5 supervisor match, target 10 ahead
    wr_reg(3'd1, 64'd500);
    wr_reg(3'd0, 64'd490);
    expect_rise(0, cyc + 11, "R5 supervisor rise cycle");
    idle(15);
    rd_reg(3'd3, d); check("R5 timer bit in soft register", d, 64'h10000);
    // R3 one shot: reload below target, no second event
    wr_reg(3'd5, 64'h10000);
    wr_reg(3'd0, 64'd495);
    idle(12);
    check("R3 no second event", {63'd0, soft_timer_irq}, 64'd0);

    // R4 disabled compare
    wr_reg(3'd1, DIS | 64'd520);
    wr_reg(3'd0, 64'd515);
    idle(12);
    rd_reg(3'd3, d); check("R4 disabled compare silent", d, 64'd0);

    // R4 cancel before match
    wr_reg(3'd1, 64'd600);
    wr_reg(3'd0, 64'd590);
    idle(3);
    wr_reg(3'd1, DIS | 64'd600);
    idle(15);
    check("R4 cancelled compare silent", {63'd0, soft_timer_irq}, 64'd0);

    // R10 target below counter while running, then wrap
    wr_reg(3'd0, 64'd800);
    wr_reg(3'd1, 64'd700);
    idle(20);
    check("R10 no event below counter", {63'd0, soft_timer_irq}, 64'd0);
    wr_reg(3'd1, 64'd2);
    wr_reg(3'd0, 64'h7FFF_FFFF_FFFF_FFFD);
    expect_rise(0, cyc + 6, "R1 R10 event after wrap");
    idle(10);
    check("R10 wrap event seen", {63'd0, soft_timer_irq}, 64'd1);

    // R11 soft register write modes
    wr_reg(3'd3, 64'd0);
    wr_reg(3'd4, 64'h9);
    rd_reg(3'd4, d); check("R11 set mode", d, 64'h9);
    wr_reg(3'd5, 64'h1);
    rd_reg(3'd5, d); check("R11 clear mode", d, 64'h8);
    wr_reg(3'd3, 64'h10004);
    expect_rise(0, cyc, "R11 replace sets timer bit");
    rd_reg(3'd3, d); check("R11 replace mode", d, 64'h10004);
    check("R11 output mirrors bit 16", {63'd0, soft_timer_irq}, 64'd1);
    check("R11 soft_int output", {47'd0, soft_int}, 64'h10004);
    wr_reg(3'd3, 64'd0);

    // R6/R7 hypervisor match and clear
    wr_reg(3'd2, 64'd300);
    wr_reg(3'd0, 64'd297);
    expect_rise(1, cyc + 4, "R6 hypervisor rise cycle");
    idle(8);
    rd_reg(3'd6, d); check("R6 pending flag set", d, 64'd1);
    wr_reg(3'd6, 64'd0);
    check("R7 hyp_irq cleared", {63'd0, hyp_irq}, 64'd0);

    // R8 halted and unallocated drop hypervisor match
    strand_state = 2'd2;
    wr_reg(3'd2, 64'd400);
    wr_reg(3'd0, 64'd395);
    idle(10);
    check("R8 halted drops match", {63'd0, hyp_irq}, 64'd0);
    strand_state = 2'd3;
    wr_reg(3'd2, 64'd450);
    wr_reg(3'd0, 64'd445);
    idle(10);
    rd_reg(3'd6, d); check("R8 unallocated drops match", d, 64'd0);
    strand_state = 2'd0;
    idle(4);
    check("R8 dropped match stays consumed", {63'd0, hyp_irq}, 64'd0);

    // R9 suspended late delivery
    strand_state = 2'd1;
    wr_reg(3'd0, 64'd5000);
    wr_reg(3'd1, 64'd4000);
    expect_rise(0, cyc + 1, "R9 late supervisor event");
    idle(5);
    wr_reg(3'd5, 64'h10000);
    wr_reg(3'd2, 64'd4500);
    expect_rise(1, cyc + 1, "R9 late hypervisor event");
    idle(5);
    strand_state = 2'd0;
    wr_reg(3'd6, 64'd0);
    idle(3);

    finish_run();
  end

endmodule